// File: doc/BRIEF.md
# MDIO Management Master

This block is the serial management master that a MAC subsystem uses to reach external PHY devices over the two-wire management bus. Software fills three registers through a small synchronous register port: a configuration word, an address word and a data word. It then writes a fourth, the command word, to launch one frame. The block derives the management clock from the system clock through a programmable divider. It drives the data line with a separate output enable and samples the returned data. It reports progress through a busy bit in the command word.

One register set serves both frame families. A start code of 00 selects the extended (clause 45 style) family, with four opcodes: address, write, read with post-increment, and read. Any other start code selects the classic (clause 22 style) family, where opcode 1 writes and opcode 2 reads. A frame can be preceded by 32 ones of preamble. The returned data can be inverted, or input sampling can be switched off. In the classic family, the register address can step by one after each completed frame.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read back as zero, `mdc` is low and `mdio_oe` is low.
- R2: The register port selects by `bus_addr`: 0 configuration, 1 address, 2 data, 3 command. Configuration bits are: bit 0 sample enable, bit 1 input invert, bit 2 preamble enable, bits 4:3 start code, bits 12:5 divider. Address bits are: bits 4:0 register/device address, bits 9:5 PHY address. Data uses bits 15:0. Command bits are: bits 1:0 opcode, bit 2 autoincrement, bit 31 busy (read-only). Unused bits read as zero.
- R3: While a frame runs, `mdc` has a period of 2*(divider+1) system clocks. It is low whenever the block is idle.
- R4: With the preamble enabled, a frame starts with 32 ones. With it disabled, the frame starts directly with the start code.
- R5: After any preamble, the frame sends MSB first: start code (2 bits), opcode (2), PHY address (5), register address (5), turnaround (2), data (16). A frame with opcode bit 1 clear uses turnaround 10 and sends the data register.
- R6: Opcode bit 1 set marks a read in both families: classic opcodes 2 and 3, and extended read-increment and read. The block releases `mdio_oe` from the turnaround through the last data bit. It drives all other bits, including the whole preamble.
- R7: `mdio_o` changes only when `mdc` falls or when a frame starts; it never changes while `mdc` is high. `mdio_i` is sampled when `mdc` rises.
- R8: Busy sets on the clock after an accepted command write. It clears with the falling `mdc` edge that ends the last bit, giving exactly 32 or 64 rising edges per frame.
- R9: A command write while busy is ignored: the opcode and autoincrement fields keep their values and the running frame is unchanged.
- R10: At the end of a read, the data register holds the 16 sampled bits, first-received bit as bit 15, each XORed with the invert bit.
- R11: With sampling disabled, a read leaves 0xFFFF in the data register.
- R12: In the classic family with autoincrement set, the register address increases by one after each frame and wraps from 31 to 0. In the extended family it stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or a frame snapshot taken at the wrong time shows up as a wrong bit at a rising `mdc` edge, or as a wrong number of edges. The PHY model catches either within the same frame. A divider fault shows within the first two rising edges as a wrong period. A sampling or turnaround fault shows as a wrong output enable or as wrong read data. That data is visible in the data register as soon as busy drops. Bookkeeping faults in the address or command registers show up on the register read that follows each frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int DIV_W     = 8;
  localparam int REGA_W    = 5;
  localparam int PHYA_W    = 5;
  localparam int DATA_W    = 16;
  localparam int OP_W      = 2;
  localparam int SOF_W     = 2;
  localparam int TA_W      = 2;
  localparam int BUS_W     = 32;
  localparam int PRE_LEN   = 32;
  localparam int HDR_LEN   = SOF_W + OP_W + PHYA_W + REGA_W;
  localparam int FRAME_LEN = HDR_LEN + TA_W + DATA_W;
  localparam int TA_POS    = HDR_LEN;
  localparam int DATA_POS  = HDR_LEN + TA_W;
  localparam int IDX_W     = $clog2(PRE_LEN + FRAME_LEN + 1);
  localparam int FIDX_W    = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CMD  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [SOF_W-1:0] sof;
    logic             pre_en;
    logic             inv;
    logic             smp_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic logic is_read(input logic [OP_W-1:0] op);
    return op[1];
  endfunction

  function automatic logic is_classic(input logic [SOF_W-1:0] sof);
    return sof != '0;
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic [SOF_W-1:0]  sof,
    input logic [OP_W-1:0]   op,
    input logic [PHYA_W-1:0] phy,
    input logic [REGA_W-1:0] rega,
    input logic [DATA_W-1:0] data);
    if (is_read(op))
      return {sof, op, phy, rega, {TA_W{1'b1}}, {DATA_W{1'b1}}};
    return {sof, op, phy, rega, 2'b10, data};
  endfunction

  function automatic logic [IDX_W-1:0] last_index(input logic pre);
    return pre ? IDX_W'(PRE_LEN + FRAME_LEN - 1) : IDX_W'(FRAME_LEN - 1);
  endfunction

  function automatic logic [REGA_W-1:0] bump_addr(input logic [REGA_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv
  import mdio_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic                 rd_in,
  input  logic                 pre_in,
  input  logic                 smp_in,
  input  logic                 inv_in,
  input  logic                 tick,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 rise_evt,
  output logic                 fall_evt,
  output logic                 done,
  output logic                 rd_snap,
  output logic                 smp_snap,
  output logic [DATA_W-1:0]    rd_data
);
  logic                 busy_q, mdc_q, pre_q, inv_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic [DATA_W-1:0]    rsh_q;
  logic                 in_pre, last, released, sample;
  logic [IDX_W-1:0]     fpos;
  logic [FIDX_W-1:0]    fidx;

  assign in_pre   = pre_q && (idx_q < IDX_W'(PRE_LEN));
  assign fpos     = idx_q - (pre_q ? IDX_W'(PRE_LEN) : IDX_W'(0));
  assign fidx     = fpos[FIDX_W-1:0];
  assign last     = (idx_q == last_index(pre_q));
  assign rise_evt = busy_q && tick && !mdc_q;
  assign fall_evt = busy_q && tick && mdc_q;
  assign done     = fall_evt && last;
  assign released = rd_snap && !in_pre && (fidx >= FIDX_W'(TA_POS));
  assign sample   = rise_evt && !in_pre && (fidx >= FIDX_W'(DATA_POS));

  assign busy    = busy_q;
  assign mdc     = mdc_q;
  assign mdio_o  = !busy_q || in_pre || frame_q[FIDX_W'(FRAME_LEN-1) - fidx];
  assign mdio_oe = busy_q && !released;
  assign rd_data = smp_snap ? rsh_q : {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      mdc_q    <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      rd_snap  <= 1'b0;
      pre_q    <= 1'b0;
      smp_snap <= 1'b0;
      inv_q    <= 1'b0;
      rsh_q    <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      mdc_q    <= 1'b0;
      idx_q    <= '0;
      frame_q  <= frame_in;
      rd_snap  <= rd_in;
      pre_q    <= pre_in;
      smp_snap <= smp_in;
      inv_q    <= inv_in;
    end else if (busy_q) begin
      if (rise_evt) mdc_q <= 1'b1;
      if (sample)   rsh_q <= {rsh_q[DATA_W-2:0], mdio_i ^ inv_q};
      if (fall_evt) begin
        mdc_q <= 1'b0;
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              eng_rd,
  input  logic [DATA_W-1:0] eng_data,
  output logic              start,
  output cfg_t              cfg_q,
  output logic [PHYA_W-1:0] phy_q,
  output logic [REGA_W-1:0] rega_q,
  output logic [DATA_W-1:0] data_q,
  output logic [OP_W-1:0]   op_q,
  output logic              autoinc_q,
  output logic              classic_q,
  output logic [BUS_W-1:0]  bus_rdata
);
  reg_sel_e sel;
  assign sel   = reg_sel_e'(bus_addr);
  assign start = bus_wr && (sel == SEL_CMD) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      phy_q     <= '0;
      rega_q    <= '0;
      data_q    <= '0;
      op_q      <= '0;
      autoinc_q <= 1'b0;
      classic_q <= 1'b0;
    end else begin
      if (done && eng_rd)                data_q <= eng_data;
      if (done && classic_q && autoinc_q) rega_q <= bump_addr(rega_q);
      if (start) begin
        op_q      <= bus_wdata[OP_W-1:0];
        autoinc_q <= bus_wdata[OP_W];
        classic_q <= is_classic(cfg_q.sof);
      end
      if (bus_wr && sel == SEL_CFG) cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
      if (bus_wr && sel == SEL_ADDR) begin
        rega_q <= bus_wdata[REGA_W-1:0];
        phy_q  <= bus_wdata[REGA_W +: PHYA_W];
      end
      if (bus_wr && sel == SEL_DATA) data_q <= bus_wdata[DATA_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CFG:  bus_rdata = {{(BUS_W-CFG_W){1'b0}}, cfg_q};
      SEL_ADDR: bus_rdata = {{(BUS_W-PHYA_W-REGA_W){1'b0}}, phy_q, rega_q};
      SEL_DATA: bus_rdata = {{(BUS_W-DATA_W){1'b0}}, data_q};
      default:  bus_rdata = {busy, {(BUS_W-OP_W-2){1'b0}}, autoinc_q, op_q};
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 start, busy, tick, rise_evt, fall_evt, done;
  logic                 eng_rd, smp_snap, autoinc_q, classic_q;
  logic [DATA_W-1:0]    eng_data, data_q;
  logic [PHYA_W-1:0]    phy_q;
  logic [REGA_W-1:0]    rega_q;
  logic [OP_W-1:0]      op_q;
  logic [FRAME_LEN-1:0] frame;
  cfg_t                 cfg_q;

  assign frame = build_frame(cfg_q.sof, bus_wdata[OP_W-1:0], phy_q, rega_q, data_q);

  mdio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done),
    .eng_rd    (eng_rd),
    .eng_data  (eng_data),
    .start     (start),
    .cfg_q     (cfg_q),
    .phy_q     (phy_q),
    .rega_q    (rega_q),
    .data_q    (data_q),
    .op_q      (op_q),
    .autoinc_q (autoinc_q),
    .classic_q (classic_q),
    .bus_rdata (bus_rdata)
  );

  mdio_clkdiv #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div   (cfg_q.div),
    .tick  (tick)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .frame_in (frame),
    .rd_in    (is_read(bus_wdata[OP_W-1:0])),
    .pre_in   (cfg_q.pre_en),
    .smp_in   (cfg_q.smp_en),
    .inv_in   (cfg_q.inv),
    .tick     (tick),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .done     (done),
    .rd_snap  (eng_rd),
    .smp_snap (smp_snap),
    .rd_data  (eng_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        tick,
  input logic        fall_evt,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [1:0]  op_q,
  input logic        autoinc_q,
  input logic        classic_q,
  input logic [4:0]  rega_q,
  input logic [15:0] data_q,
  input logic        eng_rd,
  input logic        smp_snap
);
  // R8
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R8
  end_of_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !mdc));

  // R3
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R3
  mdc_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mdc));

  // R7
  mdo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_evt) |=> $stable(mdio_o));

  // R9
  cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && busy) |=> ($stable(op_q) && $stable(autoinc_q)));

  // R11
  no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && eng_rd && !smp_snap && !(bus_wr && bus_addr == 2'd2)) |=> data_q == 16'hFFFF);

  // R12
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && classic_q && autoinc_q && rega_q == 5'd31 && !(bus_wr && bus_addr == 2'd1))
      |=> rega_q == 5'd0);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .tick      (tick),
  .fall_evt  (fall_evt),
  .done      (done),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .op_q      (op_q),
  .autoinc_q (autoinc_q),
  .classic_q (classic_q),
  .rega_q    (rega_q),
  .data_q    (data_q),
  .eng_rd    (eng_rd),
  .smp_snap  (smp_snap)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model
  int          nrise = 0;
  int          prelen = 0;
  logic [15:0] resp = 16'h0;
  realtime     t0 = 0.0, t1 = 0.0;
  logic        cap_o  [0:63];
  logic        cap_oe [0:63];
  int          r7_bad = 0;
  logic        prev_mdo = 1'b1;

  always @(posedge mdc) begin
    if (nrise < 64) begin
      cap_o[nrise]  = mdio_o;
      cap_oe[nrise] = mdio_oe;
    end
    if (nrise == 0) t0 = $realtime;
    if (nrise == 1) t1 = $realtime;
    nrise++;
  end

  always @(negedge mdc) begin
    int f;
    #1;
    f = nrise - prelen;
    if (f >= 16 && f <= 31) mdio_i = resp[31 - f];
    else                    mdio_i = 1'b1;
  end

  // R7: data out must not move while mdc is high
  always @(negedge clk) begin
    if (rst_n && mdc && (mdio_o !== prev_mdo)) r7_bad++;
    prev_mdo = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd3, v);
      if (!v[31]) return;
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic [1:0] sof, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rega, input logic [15:0] data);
    logic [31:0] w;
    w[31:30] = sof;
    w[29:28] = op;
    w[27:23] = phy;
    w[22:18] = rega;
    w[17:16] = 2'b10;
    w[15:0]  = data;
    return w;
  endfunction

  function automatic logic [15:0] exp_read(input logic smp, input logic inv, input logic [15:0] r);
    if (!smp) return 16'hFFFF;
    return inv ? ~r : r;
  endfunction

  task automatic run_op(input logic [7:0] div, input logic [1:0] sof, input logic pre,
      input logic inv, input logic smp, input logic [4:0] phy, input logic [4:0] rega,
      input logic [15:0] data, input logic [1:0] op, input logic ainc,
      input logic [15:0] rsp, input bit poke, input string tag);
    logic [31:0] v, w;
    int len, mism;
    logic eb, eoe;
    logic [15:0] ed;
    logic [4:0] ea;
    prelen = pre ? 32 : 0;
    resp = rsp;
    wr(2'd0, {19'd0, div, sof, pre, inv, smp});
    wr(2'd1, {22'd0, phy, rega});
    wr(2'd2, {16'd0, data});
    nrise = 0;
    wr(2'd3, {29'd0, ainc, op});
    if (poke) begin
      wr(2'd3, {29'd0, ~ainc, ~op});
      rd(2'd3, v);
      // R9: command field kept, busy still visible (R8)
      chk(v[2:0] == {ainc, op} && v[31], {"R9 R8 cmd locked ", tag}, v, {1'b1, 28'd0, ainc, op});
    end
    wait_idle();
    len = prelen + 32;
    chk(nrise == len, {"R8 edge count ", tag}, nrise, len);
    w = exp_frame(sof, op, phy, rega, data);
    mism = 0;
    for (int k = 0; k < len && k < 64; k++) begin
      eb  = (k < prelen) ? 1'b1 : w[31 - (k - prelen)];
      eoe = (k < prelen) || !(op[1] && (k - prelen) >= 14);
      if (cap_oe[k] !== eoe) mism++;
      if (eoe && cap_o[k] !== eb) mism++;
    end
    chk(mism == 0, {"R4 R5 R6 frame bits ", tag}, mism, 0);
    chk(int'((t1 - t0) / 4.0) == 2 * (int'(div) + 1), {"R3 mdc period ", tag},
        int'((t1 - t0) / 4.0), 2 * (int'(div) + 1));
    rd(2'd2, v);
    ed = op[1] ? exp_read(smp, inv, rsp) : data;
    chk(v == {16'd0, ed}, {"R7 R10 R11 data reg ", tag}, v, {16'd0, ed});
    rd(2'd1, v);
    ea = rega + ((sof != 2'b00 && ainc) ? 5'd1 : 5'd0);
    chk(v == {22'd0, phy, ea}, {"R12 addr reg ", tag}, v, {22'd0, phy, ea});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 32'd0, "R1 reset register", v, 32'd0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", {mdc, mdio_oe}, 0);

    // R2 field widths and read-back
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v);
    chk(v == 32'h0000_1FFF, "R2 cfg readback", v, 32'h1FFF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v);
    chk(v == 32'h0000_03FF, "R2 addr readback", v, 32'h3FF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v);
    chk(v == 32'h0000_FFFF, "R2 data readback", v, 32'hFFFF);

    // directed corners
    run_op(8'd0, 2'b01, 1'b0, 1'b0, 1'b1, 5'h11, 5'h0A, 16'hA5C3, 2'b01, 1'b0, 16'h0, 1'b0, "classic write div0 nopre");
    run_op(8'd2, 2'b01, 1'b1, 1'b0, 1'b1, 5'h03, 5'd31, 16'h0000, 2'b10, 1'b1, 16'h9B17, 1'b0, "classic read wrap");
    run_op(8'd1, 2'b00, 1'b1, 1'b1, 1'b1, 5'h1F, 5'h05, 16'h1234, 2'b10, 1'b1, 16'h6C01, 1'b0, "ext read-inc inverted no step");
    run_op(8'd1, 2'b00, 1'b0, 1'b0, 1'b0, 5'h07, 5'h02, 16'h5555, 2'b11, 1'b0, 16'h0F0F, 1'b0, "ext read sampling off");
    run_op(8'd3, 2'b00, 1'b0, 1'b0, 1'b1, 5'h02, 5'h1E, 16'hBEEF, 2'b00, 1'b0, 16'h0, 1'b0, "ext address frame");
    run_op(8'd7, 2'b01, 1'b1, 1'b0, 1'b1, 5'h15, 5'h0C, 16'hC0DE, 2'b01, 1'b1, 16'h0, 1'b1, "busy command ignored");

    // constrained random
    for (int n = 0; n < 16; n++) begin
      run_op(8'($urandom % 4), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             5'($urandom), 5'($urandom), 16'($urandom), 2'($urandom), 1'($urandom),
             16'($urandom), 1'b0, "random");
    end

    chk(r7_bad == 0, "R7 mdio_o moved while mdc high", r7_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule